// File: doc/BRIEF.md
# Selectable Multi-Waveform Sample Generator

This block produces 8-bit unsigned sample codes for an external D/A converter. Six free-running shape generators share one sample clock and one active-low asynchronous reset: a falling sawtooth, a rising sawtooth, a square wave, a triangle, a staircase and a 64-point sine. A 3-bit select input picks which generator feeds the registered output. Every generator keeps stepping while it is not selected, so switching the select lands on the current phase of that shape rather than restarting it.

Each generator steps once per advance. By default the system clock is the sample clock and every clock is an advance. An optional prescaler stretches this: it is a chain of divider stages, and each stage toggles its level after `PRE_DIV` input ticks. The output then moves only on the rising edge of the last stage.

Top module: `multiwave_gen`

## Requirements
- R1: While `rst_n` is low, `sample` is 0 at once, without waiting for a clock. After release, advance n (n counted from 0) loads `sample` with the value that the selected generator holds after n earlier advances.
- R2: Select 000 gives the falling sawtooth: 255 after reset, minus 1 per advance, and 255 again on the advance after 0.
- R3: Select 001 gives the rising sawtooth: 0 after reset, plus 1 per advance, and 0 again on the advance after 255.
- R4: Select 010 gives the square wave. It shows only 0 or 255, starts with 32 advances of 0, then alternates every 32 advances, for a period of 64.
- R5: Select 011 gives the triangle. It goes from 0 to 255 and back to 0 in steps of 1, with a period of 510. Both 0 and 255 appear for exactly one advance.
- R6: Select 100 gives the staircase. Level k (0 to 7) is k*32 and lasts `STAIR_DWELL` advances (default 1). After 224 it returns to 0.
- R7: Select 101 gives the sine. Its index runs 0 to 63 and wraps to 0. Index 0 and index 63 give 255, indices 31 and 32 give 0, and indices 16 and 47 give 124. Index i and index 63-i give the same code, and indices 1, 2 and 5 give 254, 252 and 239.
- R8: Selects 110 and 111 hold `sample` at its previous value.
- R9: The select takes effect only at the next advancing edge. Generators that are not selected keep stepping, so a newly selected shape shows its running phase.
- R10: With `USE_PRESCALE` = 1, the output and the generators advance once every (2*`PRE_DIV`)^`PRE_STAGES` clocks. `sample` is unchanged at every other clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; rising edge is active |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel | input | 3 | Waveform select code |
| sample | output | 8 | Registered unsigned sample code |

## Verification
A corrupted phase counter or direction flag inside a generator shows up at `sample` one advance after that generator is selected. It stays invisible while another shape is on the output. For that reason the stimulus moves between shapes late in the run, so that a wrong running phase, such as a missed wrap or a doubled extreme, must surface as a wrong value at a known advance count. Prescaler faults appear as the wrong spacing between output changes. With two stages of divide-by-3 levels, that spacing is 36 clocks per step.

// File: rtl/multiwave_gen.sv
module multiwave_gen #(
  parameter int SQ_HALF      = 32,
  parameter int STAIR_STEPS  = 8,
  parameter int STAIR_DWELL  = 1,
  parameter bit USE_PRESCALE = 1'b0,
  parameter int PRE_DIV      = 100,
  parameter int PRE_STAGES   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel,
  output logic [7:0] sample
);
  localparam int SQW  = (SQ_HALF > 1) ? $clog2(SQ_HALF) : 1;
  localparam int LVW  = (STAIR_STEPS > 1) ? $clog2(STAIR_STEPS) : 1;
  localparam int DWW  = (STAIR_DWELL > 1) ? $clog2(STAIR_DWELL) : 1;
  localparam logic [7:0] STEP = 8'(256 / STAIR_STEPS);
  localparam logic [LVW-1:0] LV_LAST = LVW'(STAIR_STEPS - 1);
  localparam logic [DWW-1:0] DW_LAST = DWW'(STAIR_DWELL - 1);
  localparam logic [SQW-1:0] SQ_LAST = SQW'(SQ_HALF - 1);

  logic adv;

  generate
    if (USE_PRESCALE) begin : g_pre
      localparam int PCW = $clog2(PRE_DIV);
      logic [PCW-1:0]      pcnt [PRE_STAGES];
      logic [PRE_STAGES-1:0] plvl;
      logic [PRE_STAGES:0]   tick;
      assign tick[0] = 1'b1;
      for (genvar s = 0; s < PRE_STAGES; s++) begin : g_stage
        assign tick[s+1] = tick[s] && (pcnt[s] == PCW'(PRE_DIV - 1)) && !plvl[s];
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            pcnt[s] <= '0;
            plvl[s] <= 1'b0;
          end else if (tick[s]) begin
            if (pcnt[s] == PCW'(PRE_DIV - 1)) begin
              pcnt[s] <= '0;
              plvl[s] <= ~plvl[s];
            end else begin
              pcnt[s] <= pcnt[s] + 1'b1;
            end
          end
        end
      end
      assign adv = tick[PRE_STAGES];
    end else begin : g_nopre
      assign adv = 1'b1;
    end
  endgenerate

  logic [7:0]     fall_v, rise_v, tri_v;
  logic           tri_dn, sq_hi;
  logic [SQW-1:0] sq_cnt;
  logic [LVW-1:0] st_lvl;
  logic [DWW-1:0] st_dw;
  logic [5:0]     sin_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fall_v  <= 8'd255;
      rise_v  <= 8'd0;
      tri_v   <= 8'd0;
      tri_dn  <= 1'b0;
      sq_hi   <= 1'b0;
      sq_cnt  <= '0;
      st_lvl  <= '0;
      st_dw   <= '0;
      sin_idx <= '0;
    end else if (adv) begin
      fall_v  <= fall_v - 8'd1;
      rise_v  <= rise_v + 8'd1;
      sin_idx <= sin_idx + 6'd1;
      if (sq_cnt == SQ_LAST) begin
        sq_cnt <= '0;
        sq_hi  <= ~sq_hi;
      end else begin
        sq_cnt <= sq_cnt + 1'b1;
      end
      if (!tri_dn) begin
        tri_v <= tri_v + 8'd1;
        if (tri_v == 8'd254) tri_dn <= 1'b1;
      end else begin
        tri_v <= tri_v - 8'd1;
        if (tri_v == 8'd1) tri_dn <= 1'b0;
      end
      if (st_dw == DW_LAST) begin
        st_dw  <= '0;
        st_lvl <= (st_lvl == LV_LAST) ? '0 : st_lvl + 1'b1;
      end else begin
        st_dw <= st_dw + 1'b1;
      end
    end
  end

  function automatic logic [7:0] sine_half(input logic [4:0] i);
    case (i)
      5'd0:  return 8'd255; 5'd1:  return 8'd254; 5'd2:  return 8'd252; 5'd3:  return 8'd249;
      5'd4:  return 8'd245; 5'd5:  return 8'd239; 5'd6:  return 8'd233; 5'd7:  return 8'd225;
      5'd8:  return 8'd217; 5'd9:  return 8'd207; 5'd10: return 8'd197; 5'd11: return 8'd186;
      5'd12: return 8'd174; 5'd13: return 8'd162; 5'd14: return 8'd150; 5'd15: return 8'd137;
      5'd16: return 8'd124; 5'd17: return 8'd112; 5'd18: return 8'd99;  5'd19: return 8'd87;
      5'd20: return 8'd75;  5'd21: return 8'd64;  5'd22: return 8'd53;  5'd23: return 8'd43;
      5'd24: return 8'd34;  5'd25: return 8'd26;  5'd26: return 8'd19;  5'd27: return 8'd13;
      5'd28: return 8'd8;   5'd29: return 8'd4;   5'd30: return 8'd1;   default: return 8'd0;
    endcase
  endfunction

  wire [7:0] sin_v   = sine_half(sin_idx[5] ? ~sin_idx[4:0] : sin_idx[4:0]);
  wire [7:0] stair_v = 8'(st_lvl) * STEP;
  wire [7:0] sq_v    = sq_hi ? 8'd255 : 8'd0;

  logic [7:0] pick;
  always_comb begin
    case (sel)
      3'd0:    pick = fall_v;
      3'd1:    pick = rise_v;
      3'd2:    pick = sq_v;
      3'd3:    pick = tri_v;
      3'd4:    pick = stair_v;
      3'd5:    pick = sin_v;
      default: pick = sample;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sample <= 8'd0;
    else if (adv) sample <= pick;
  end

  a_r2_fall_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && fall_v == 8'd0) |=> fall_v == 8'd255);
  a_r3_rise_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && rise_v == 8'd255) |=> rise_v == 8'd0);
  a_r4_square_levels: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && sel == 3'd2) |=> (sample == 8'd0 || sample == 8'd255));
  a_r5_peak_once: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && tri_v == 8'd255) |=> tri_v == 8'd254);
  a_r5_floor_once: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && tri_v == 8'd0 && tri_dn) |=> tri_v == 8'd1);
  a_r6_stair_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && st_lvl == LV_LAST && st_dw == DW_LAST) |=> st_lvl == '0);
  a_r7_sine_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && sin_idx == 6'd63) |=> sin_idx == 6'd0);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sel[2:1] == 2'b11) |=> $stable(sample));
  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(sample));
endmodule

// File: tb/tb_multiwave_gen.sv
`timescale 1ns/1ps
module tb_multiwave_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] sel = 3'd0;
  logic [7:0] sample, sample_p;
  int checks = 0, failures = 0, edges = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  multiwave_gen dut (.clk(clk), .rst_n(rst_n), .sel(sel), .sample(sample));
  multiwave_gen #(.USE_PRESCALE(1'b1), .PRE_DIV(3), .PRE_STAGES(2), .STAIR_DWELL(2))
    dut_pre (.clk(clk), .rst_n(rst_n), .sel(3'd4), .sample(sample_p));

  localparam int N = 36;
  // columns: edge number after release, select, expected sample, requirement
  localparam int V_E[N] = '{1,2,3,10,32,33,64,65,70,256,257,258,300,510,511,512,765,766,767,
                            800,801,810,833,834,849,864,865,880,896,897,898,899,900,901,902,904};
  localparam int V_S[N] = '{0,1,0,2,2,2,2,2,3,1,1,0,3,3,3,3,3,3,3,
                            4,4,4,5,5,5,5,5,5,5,5,5,5,6,7,5,0};
  localparam int V_X[N] = '{255,1,253,0,0,255,255,0,69,255,0,254,211,1,0,1,254,255,254,
                            224,0,32,255,254,124,0,0,124,255,255,254,252,252,252,239,120};
  localparam int V_R[N] = '{2,3,2,4,4,4,4,4,5,3,3,2,5,5,5,5,5,5,5,
                            6,6,6,7,7,7,7,7,7,7,7,7,7,8,8,7,9};
  // R2 R3 R4 R5 R6 R7 R8 R9 rows above

  task automatic step();
    @(posedge clk);
    edges++;
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #5;
    chk(sample == 8'd0, "R1", sample, 0);
    @(negedge clk);
    rst_n = 1'b1;
    edges = 0;
    for (int i = 0; i < N; i++) begin
      while (edges < V_E[i] - 1) step();
      sel = 3'(V_S[i]);
      step();
      chk(sample == 8'(V_X[i]), $sformatf("R%0d row%0d", V_R[i], i), sample, V_X[i]);
    end
    // R9: select change not visible before the edge
    sel = 3'd1;
    #1;
    chk(sample == 8'd120, "R9", sample, 120);
    step();
    chk(sample == 8'd136, "R9", sample, 136);
    // R1: asynchronous reset mid-cycle
    #0.5 rst_n = 1'b0;
    #0.5;
    chk(sample == 8'd0, "R1", sample, 0);
    @(negedge clk);
    rst_n = 1'b1;
    edges = 0;
    sel = 3'd1;
    step();
    chk(sample == 8'd0, "R1", sample, 0);
    step();
    chk(sample == 8'd1, "R1", sample, 1);
    // R10: prescaled staircase, dwell 2, one advance per 36 clocks
    begin
      int waited = 0;
      int bad = 0;
      while (sample_p != 8'd32 && waited < 300) begin
        step();
        waited++;
      end
      chk(sample_p == 8'd32, "R10", sample_p, 32);
      chk(waited > 36, "R10", waited, 37);
      for (int k = 1; k < 72; k++) begin
        step();
        if (sample_p != 8'd32) bad++;
      end
      chk(bad == 0, "R10", bad, 0);
      step();
      chk(sample_p == 8'd64, "R10", sample_p, 64);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule